// File: doc/BRIEF.md
# Transition-Filtered Operation Status Group

This block collects a vector of live operation status signals and turns selected changes on them into sticky event flags. Each cycle it registers the inputs into a condition register and compares that value with the condition seen one clock before. For every bit, a 0-to-1 change counts as an event when the matching bit of the rising-edge filter is set. A 1-to-0 change counts when the matching bit of the falling-edge filter is set. A bit set in both filters catches either edge. Qualified changes set bits in an event register, and those bits stay set until host software reads that register.

An enable mask selects which event bits feed a single summary output. The summary is the OR of the event bits ANDed with the enable bits, and it drives bit 7 of the status byte, which lives outside this block. Through a small register port the host reads the condition and event registers and reads or writes the two filters and the enable mask. A read of the event register returns its contents and clears it. A change that qualifies in the same cycle as that read is kept, so no event is lost.

Top module: `stat_group_top`

## Requirements
- R1: A read at address 0 returns the condition register, which holds `status_in` as registered on the clock edge before the read edge.
- R2: When a condition bit goes from 0 to 1 and the same bit of the rising filter (address 1) is 1, the event bit is set on the next clock edge.
- R3: When a condition bit goes from 1 to 0 and the same bit of the falling filter (address 2) is 1, the event bit is set on the next clock edge.
- R4: A change on a condition bit whose filter bit for that direction is 0 leaves the event bit unchanged.
- R5: Event bits stay set until the event register (address 3) is read. That read returns the current value and clears the register on the same edge.
- R6: When a change qualifies in the same cycle as a read of address 3, the read returns the old value and the newly qualified bit stays set afterwards.
- R7: `summary` is 1 exactly when some event bit and the same enable bit (address 4) are both 1. It follows both registers without any extra delay.
- R8: A write at address 1, 2 or 4 loads `wdata` into that register, and a later read of that address returns the written value.
- R9: Writes at address 0 or 3 change no register. A read at any address from 5 to 7 returns zero.
- R10: After reset the rising filter is all ones. The falling filter, enable mask, event register, condition history and `summary` are all zero.
- R11: `rdata` is loaded on the clock edge where `rd_en` is high and holds its value while `rd_en` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| status_in | input | WIDTH | Live operation status signals |
| rd_en | input | 1 | Host read strobe; a read of address 3 clears the event register |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Register select: 0 condition, 1 rising filter, 2 falling filter, 3 event, 4 enable |
| wdata | input | WIDTH | Host write data |
| rdata | output | WIDTH | Registered host read data |
| summary | output | 1 | OR of event bits masked by the enable register, for status byte bit 7 |

## Verification
The assertions check the following on every cycle. Any edge that passes a filter appears in the event register on the next edge, including on a clearing read. An event bit never appears without a qualified edge behind it, and it never falls unless a read of the event register came just before. Writes to the read-only addresses leave the writable registers alone, and read data holds between reads. Some behaviour can only be shown by the bench's scenarios, because it depends on what the host sees at the port. These are the value a read returns at the moment it clears the register, the reset contents, the round trip of filter and mask writes, the zero read at unmapped addresses, and the catching of both edges when a bit is set in both filters.

// File: rtl/stat_pkg.sv
package stat_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SG_COND = 3'd0,
    SG_RISE = 3'd1,
    SG_FALL = 3'd2,
    SG_EVT  = 3'd3,
    SG_MASK = 3'd4
  } sg_addr_e;

endpackage

// File: rtl/stat_rst_sync.sv
module stat_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/stat_edge_qual.sv
module stat_edge_qual #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] status_in,
  input  logic [WIDTH-1:0] rise_flt,
  input  logic [WIDTH-1:0] fall_flt,
  output logic [WIDTH-1:0] cond_q,
  output logic [WIDTH-1:0] hist_q,
  output logic [WIDTH-1:0] qual
);

  logic [WIDTH-1:0] cond_d;
  logic [WIDTH-1:0] hist_d;

  always_comb begin
    cond_d = status_in;
    hist_d = cond_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      hist_q <= '0;
    end else begin
      cond_q <= cond_d;
      hist_q <= hist_d;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic went_up;
    logic went_down;
    assign went_up   =  cond_q[b] & ~hist_q[b];
    assign went_down = ~cond_q[b] &  hist_q[b];
    assign qual[b]   = (went_up & rise_flt[b]) | (went_down & fall_flt[b]);
  end

endmodule

// File: rtl/stat_event_latch.sv
module stat_event_latch #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] qual,
  input  logic             clr,
  output logic [WIDTH-1:0] event_q
);

  logic [WIDTH-1:0] event_d;
  logic             event_ce;

  always_comb begin
    event_ce = clr | (|qual);
    if (clr) begin
      event_d = qual;
    end else begin
      event_d = event_q | qual;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      event_q <= '0;
    end else if (event_ce) begin
      event_q <= event_d;
    end
  end

endmodule

// File: rtl/stat_host_regs.sv
module stat_host_regs
  import stat_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  cond_q,
  input  logic [WIDTH-1:0]  event_q,
  output logic [WIDTH-1:0]  rise_q,
  output logic [WIDTH-1:0]  fall_q,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  rdata,
  output logic              evt_clr
);

  logic             rise_ce;
  logic             fall_ce;
  logic             mask_ce;
  logic [WIDTH-1:0] rd_mux;

  always_comb begin
    rise_ce = wr_en && (addr == SG_RISE);
    fall_ce = wr_en && (addr == SG_FALL);
    mask_ce = wr_en && (addr == SG_MASK);
    evt_clr = rd_en && (addr == SG_EVT);
  end

  always_comb begin
    case (addr)
      SG_COND: rd_mux = cond_q;
      SG_RISE: rd_mux = rise_q;
      SG_FALL: rd_mux = fall_q;
      SG_EVT:  rd_mux = event_q;
      SG_MASK: rd_mux = mask_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '1;
    end else if (rise_ce) begin
      rise_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
    end else if (fall_ce) begin
      fall_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_ce) begin
      mask_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/stat_group_top.sv
module stat_group_top
  import stat_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  status_in,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              summary
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] cond_q;
  logic [WIDTH-1:0] hist_q;
  logic [WIDTH-1:0] qual;
  logic [WIDTH-1:0] event_q;
  logic [WIDTH-1:0] rise_q;
  logic [WIDTH-1:0] fall_q;
  logic [WIDTH-1:0] mask_q;
  logic             evt_clr;

  stat_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stat_edge_qual #(.WIDTH(WIDTH)) u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .status_in (status_in),
    .rise_flt  (rise_q),
    .fall_flt  (fall_q),
    .cond_q    (cond_q),
    .hist_q    (hist_q),
    .qual      (qual)
  );

  stat_event_latch #(.WIDTH(WIDTH)) u_evt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .qual    (qual),
    .clr     (evt_clr),
    .event_q (event_q)
  );

  stat_host_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cond_q  (cond_q),
    .event_q (event_q),
    .rise_q  (rise_q),
    .fall_q  (fall_q),
    .mask_q  (mask_q),
    .rdata   (rdata),
    .evt_clr (evt_clr)
  );

  assign summary = |(event_q & mask_q);

endmodule

// File: rtl/stat_group_chk.sv
module stat_group_chk
  import stat_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  rdata,
  input logic              summary,
  input logic [WIDTH-1:0]  cond_q,
  input logic [WIDTH-1:0]  hist_q,
  input logic [WIDTH-1:0]  rise_q,
  input logic [WIDTH-1:0]  fall_q,
  input logic [WIDTH-1:0]  mask_q,
  input logic [WIDTH-1:0]  event_q
);

  logic [WIDTH-1:0] up_ok;
  logic [WIDTH-1:0] down_ok;
  logic             clr_rd;

  assign up_ok   = cond_q & ~hist_q & rise_q;
  assign down_ok = ~cond_q & hist_q & fall_q;
  assign clr_rd  = rd_en && (addr == SG_EVT);

  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ok != '0) |=> ((event_q & $past(up_ok)) == $past(up_ok)));

  p_fall_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (down_ok != '0) |=> ((event_q & $past(down_ok)) == $past(down_ok)));

  p_no_stray_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_q & ~$past(event_q) & ~$past(up_ok | down_ok)) == '0));

  p_sticky_until_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_rd |=> ((event_q & $past(event_q)) == $past(event_q)));

  p_summary_needs_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    summary |-> ((event_q & mask_q) != '0));

  p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == SG_COND || addr == SG_EVT))
      |=> ($stable(rise_q) && $stable(fall_q) && $stable(mask_q)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind stat_group_top stat_group_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .addr    (addr),
  .rdata   (rdata),
  .summary (summary),
  .cond_q  (cond_q),
  .hist_q  (hist_q),
  .rise_q  (rise_q),
  .fall_q  (fall_q),
  .mask_q  (mask_q),
  .event_q (event_q)
);

// File: tb/stat_group_top_tb.sv
module stat_group_top_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] status_in;
  logic         rd_en;
  logic         wr_en;
  logic [2:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic         summary;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  stat_group_top #(.WIDTH(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_in (status_in),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .summary   (summary)
  );

  // Monitor: a read sampled at a rising edge is compared at the following falling edge.
  always @(posedge clk) begin
    if (rd_en) begin
      @(negedge clk);
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data: actual %h expected none", rdata);
      end else begin
        logic [W-1:0] e;
        string        t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic do_read(input logic [2:0] a, input logic [W-1:0] e, input string t);
    rd_en = 1'b1;
    addr  = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_sum(input logic e, input string t);
    n_chk++;
    if (summary !== e) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", t, summary, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; status_in = '0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R10 reset state
    check_sum(1'b0, "R10 summary after reset");
    do_read(3'd1, 16'hFFFF, "R10 rising filter reset");
    do_read(3'd2, 16'h0000, "R10 falling filter reset");
    do_read(3'd4, 16'h0000, "R10 enable reset");
    do_read(3'd3, 16'h0000, "R10 event reset");

    // R8 write and read back
    do_write(3'd1, 16'h00FF);
    do_write(3'd2, 16'hFF00);
    do_write(3'd4, 16'h0101);
    do_read(3'd1, 16'h00FF, "R8 rising filter");
    do_read(3'd2, 16'hFF00, "R8 falling filter");
    do_read(3'd4, 16'h0101, "R8 enable");

    // R1 condition, R2 rising edges, R4 filtered-out edges
    status_in = 16'h1234;
    idle(2);
    do_read(3'd0, 16'h1234, "R1 condition read");
    check_sum(1'b0, "R7 no enabled event");
    do_read(3'd3, 16'h0034, "R2 R4 rising edges through filter");
    do_read(3'd3, 16'h0000, "R5 event cleared by read");

    // R3 falling edges and R7 summary
    status_in = 16'h0000;
    idle(2);
    check_sum(1'b0, "R7 event not enabled");
    do_write(3'd4, 16'h0200);
    check_sum(1'b1, "R7 summary follows enable");
    do_read(3'd3, 16'h1200, "R3 falling edges through filter");
    check_sum(1'b0, "R7 summary drops after clearing read");

    // R5 sticky event; the falling edge on bit 0 is filtered out (R4)
    status_in = 16'h0001;
    idle(3);
    status_in = 16'h0000;
    idle(10);
    do_read(3'd3, 16'h0001, "R5 event held until read");

    // R6 edge arriving with a clearing read
    status_in = 16'h0004;
    idle(3);
    status_in = 16'h0006;
    @(negedge clk);
    do_read(3'd3, 16'h0004, "R6 read returns old value");
    do_read(3'd3, 16'h0002, "R6 new event kept");

    // R9 read-only writes and unmapped reads
    do_write(3'd0, 16'hFFFF);
    do_write(3'd3, 16'hFFFF);
    do_read(3'd3, 16'h0000, "R9 event write ignored");
    do_read(3'd0, 16'h0006, "R9 condition write ignored");
    do_read(3'd1, 16'h00FF, "R9 rising filter untouched");
    do_read(3'd7, 16'h0000, "R9 unmapped address");
    do_read(3'd5, 16'h0000, "R9 unmapped address 5");

    // R11 rdata holds while no read
    idle(5);
    n_chk++;
    if (rdata !== 16'h0000) begin
      n_fail++;
      $display("FAIL R11 rdata hold: actual %h expected %h", rdata, 16'h0000);
    end
    do_read(3'd4, 16'h0200, "R11 rdata loads on read");
    idle(4);
    n_chk++;
    if (rdata !== 16'h0200) begin
      n_fail++;
      $display("FAIL R11 rdata hold: actual %h expected %h", rdata, 16'h0200);
    end

    // R2 R3 both edges on one bit
    do_write(3'd1, 16'h0020);
    do_write(3'd2, 16'h0020);
    status_in = 16'h0026;
    idle(2);
    do_read(3'd3, 16'h0020, "R2 both-edge bit rising");
    status_in = 16'h0006;
    idle(2);
    do_read(3'd3, 16'h0020, "R3 both-edge bit falling");
    do_read(3'd3, 16'h0000, "R5 cleared after both-edge read");

    idle(3);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule